// File: doc/BRIEF.md
# Multi-Mode Timer / PWM Counter Core

This block is a 16-bit counter that serves as a timer, a capture unit and a PWM generator. The counter can count up, count down, or count up and then down (center-aligned). It advances on a clock divided by a power of two from 1 to 128, or on an external count strobe. It compares the count against an active period value and an active compare value. Each of these has a shadow buffer. Software writes the buffer. The active value picks up the buffer contents at terminal count when that register's swap-enable is set. While the counter is stopped, a write goes straight through to the active value, so software can set initial values.

The core drives a PWM line and its inverse, single-cycle overflow, underflow and compare/capture pulses, and an interrupt pulse. All event inputs (start, stop, reload, count, capture) are single-cycle strobes that the surrounding logic has already synchronized and edge-qualified. In capture mode a capture strobe latches the current count. In compare mode the core instead reports when the count reaches the compare value.

Top module: `tpc_core`

## Requirements
- R1: After reset the count, capture value, PWM line and all pulses are 0, and the counter is stopped.
- R2: With direction 2'b00 (up) the count steps from 0 to the active period and then returns to 0; on that wrap `ovf_o` pulses for one cycle, in the same cycle the count shows 0.
- R3: With direction 2'b01 (down) the count steps down to 0, and the next step loads the active period; on that step `unf_o` pulses for one cycle.
- R4: With direction 2'b10 (up/down) the count rises to the period and falls back to 0, reversing at each end. Reaching the top pulses `ovf_o` and reaching the bottom pulses `unf_o`. Terminal count is the bottom turn only.
- R5: Unless external counting is selected, the counter steps once every 2^n clock cycles while running, where n = `cfg_div_i` (0..7). The divider restarts from zero whenever the counter is stopped.
- R6: A stop strobe freezes the count. A start strobe lets it run again. When both arrive in the same cycle, stop wins.
- R7: A reload strobe sets the count to the period in down mode and to 0 otherwise, and restarts an up/down count in its rising phase. It has priority over a step in the same cycle and does not change the running state.
- R8: A period or compare write goes only to the buffer while the counter runs. At terminal count the buffer moves to the active value when that register's swap-enable is 1, and not otherwise. A write while stopped updates both the buffer and the active value.
- R9: In compare mode (`cfg_cap_mode_i` = 0), `cc_o` pulses when a step lands the count on the active compare value, and capture strobes leave `capture_o` unchanged.
- R10: In capture mode (`cfg_cap_mode_i` = 1), a capture strobe copies the pre-edge count into `capture_o` and pulses `cc_o`. Compare matches do not pulse `cc_o`.
- R11: In up and down modes the PWM line goes to 1 at terminal count and to 0 on a compare match, and the match wins when both happen on one step. In up/down mode the line toggles on each compare match.
- R12: `line_n_o` is always the inverse of `line_o`.
- R13: `irq_o` pulses for one cycle on terminal count or on a `cc_o` pulse.
- R14: With `cfg_ext_cnt_i` = 1, the running counter steps once per `ev_count_i` strobe, and the divider has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_dir_i | input | 2 | Count direction: 00 up, 01 down, 10 up/down (11 acts as up) |
| cfg_div_i | input | 3 | Divider exponent n, step every 2^n cycles |
| cfg_cap_mode_i | input | 1 | 1 capture mode, 0 compare mode |
| cfg_ext_cnt_i | input | 1 | 1 steps on `ev_count_i` instead of the divider |
| cfg_per_swap_i | input | 1 | Period buffer swap enable at terminal count |
| cfg_cmp_swap_i | input | 1 | Compare buffer swap enable at terminal count |
| per_wr_i | input | 1 | Period buffer write strobe |
| per_data_i | input | 16 | Period write data |
| cmp_wr_i | input | 1 | Compare buffer write strobe |
| cmp_data_i | input | 16 | Compare write data |
| ev_start_i | input | 1 | Start strobe |
| ev_stop_i | input | 1 | Stop strobe |
| ev_reload_i | input | 1 | Reload strobe |
| ev_count_i | input | 1 | External count strobe |
| ev_capture_i | input | 1 | Capture strobe |
| count_o | output | 16 | Current count |
| capture_o | output | 16 | Last captured count |
| line_o | output | 1 | PWM line |
| line_n_o | output | 1 | Complementary PWM line |
| ovf_o | output | 1 | Overflow pulse |
| unf_o | output | 1 | Underflow pulse |
| cc_o | output | 1 | Compare match / capture pulse |
| irq_o | output | 1 | Interrupt pulse |

## Verification
The bench targets the turn points. A design that is off by one at the period would hold the top count for an extra step, or skip it, and every PWM duty cycle would move with it. It writes buffers while the counter runs, with swap enabled and with swap disabled. An early swap would show up as a shortened period in the middle of a cycle, and a missing swap as a period that never changes. It sends stop and start in the same cycle, and it sends capture strobes in compare mode, where a wrong priority or a leaky capture path changes the count or `capture_o`. It also runs compare values of 0 and of more than the period, and checks the divider at its largest setting, where a mask built one bit short would double the step rate.

// File: rtl/tpc_pkg.sv
package tpc_pkg;
  typedef enum logic [1:0] {
    DIR_UP   = 2'b00,
    DIR_DOWN = 2'b01,
    DIR_UPDN = 2'b10,
    DIR_RSVD = 2'b11
  } dir_e;
endpackage

// File: rtl/tpc_prescale.sv
module tpc_prescale #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int CNT_W = (1 << SEL_W) - 1;

  logic [CNT_W-1:0] pcnt_q, pcnt_d, mask;

  // low sel_i bits all ones mark the last cycle of each 2^sel window
  always_comb begin
    mask   = ~({CNT_W{1'b1}} << sel_i);
    tick_o = run_i && ((pcnt_q & mask) == mask);
    pcnt_d = run_i ? pcnt_q + CNT_W'(1) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end
endmodule

// File: rtl/tpc_dbuf.sv
module tpc_dbuf #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] data_i,
  input  logic         direct_i,
  input  logic         swap_i,
  output logic [W-1:0] act_o
);
  logic [W-1:0] buf_q, buf_d, act_q, act_d;

  always_comb begin
    buf_d = wr_i ? data_i : buf_q;
    if (wr_i && direct_i) act_d = data_i;
    else if (swap_i)      act_d = buf_q;
    else                  act_d = act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
      act_q <= '0;
    end else begin
      buf_q <= buf_d;
      act_q <= act_d;
    end
  end

  assign act_o = act_q;
endmodule

// File: rtl/tpc_step.sv
module tpc_step
  import tpc_pkg::*;
#(
  parameter int W = 16
) (
  input  dir_e         dir_i,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] per_i,
  input  logic         up_i,
  output logic [W-1:0] nxt_o,
  output logic         nxt_up_o,
  output logic         ovf_o,
  output logic         unf_o,
  output logic         tc_o
);
  always_comb begin
    nxt_o    = cnt_i + W'(1);
    nxt_up_o = up_i;
    ovf_o    = 1'b0;
    unf_o    = 1'b0;
    case (dir_i)
      DIR_DOWN: begin
        if (cnt_i == '0) begin
          nxt_o = per_i;
          unf_o = 1'b1;
        end else begin
          nxt_o = cnt_i - W'(1);
        end
      end
      DIR_UPDN: begin
        if (up_i) begin
          if (cnt_i == per_i) begin
            ovf_o    = 1'b1;
            nxt_up_o = 1'b0;
            nxt_o    = (per_i == '0) ? '0 : cnt_i - W'(1);
          end
        end else if (cnt_i == '0) begin
          unf_o    = 1'b1;
          nxt_up_o = 1'b1;
          nxt_o    = (per_i == '0) ? '0 : W'(1);
        end else begin
          nxt_o = cnt_i - W'(1);
        end
      end
      default: begin
        if (cnt_i == per_i) begin
          nxt_o = '0;
          ovf_o = 1'b1;
        end
      end
    endcase
    tc_o = unf_o | (ovf_o & (dir_i != DIR_UPDN));
  end
endmodule

// File: rtl/tpc_core.sv
module tpc_core
  import tpc_pkg::*;
#(
  parameter int CW    = 16,
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_dir_i,
  input  logic [DIV_W-1:0] cfg_div_i,
  input  logic             cfg_cap_mode_i,
  input  logic             cfg_ext_cnt_i,
  input  logic             cfg_per_swap_i,
  input  logic             cfg_cmp_swap_i,
  input  logic             per_wr_i,
  input  logic [CW-1:0]    per_data_i,
  input  logic             cmp_wr_i,
  input  logic [CW-1:0]    cmp_data_i,
  input  logic             ev_start_i,
  input  logic             ev_stop_i,
  input  logic             ev_reload_i,
  input  logic             ev_count_i,
  input  logic             ev_capture_i,
  output logic [CW-1:0]    count_o,
  output logic [CW-1:0]    capture_o,
  output logic             line_o,
  output logic             line_n_o,
  output logic             ovf_o,
  output logic             unf_o,
  output logic             cc_o,
  output logic             irq_o
);
  localparam int NBUF = 2;  // 0: period, 1: compare

  // reset: asserted asynchronously, released on a clock edge
  logic rst_m_q, rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_n <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_n <= rst_m_q;
    end
  end

  dir_e dir;
  assign dir = dir_e'(cfg_dir_i);

  logic          run_q, run_d;
  logic [CW-1:0] cnt_q, cnt_d, cap_q, cap_d;
  logic          up_q, up_d, line_q, line_d;
  logic          ovf_q, ovf_d, unf_q, unf_d, cc_q, cc_d, irq_q, irq_d;

  logic          pre_tick, tick, adv, match, tc_ev, cap_fire;
  logic [CW-1:0] nxt, per_act, cmp_act;
  logic          nxt_up, st_ovf, st_unf, st_tc;

  tpc_prescale #(.SEL_W(DIV_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_s_n),
    .run_i (run_q),
    .sel_i (cfg_div_i),
    .tick_o(pre_tick)
  );

  logic [NBUF-1:0]         b_wr, b_swap;
  logic [NBUF-1:0][CW-1:0] b_data, b_act;

  assign b_wr   = {cmp_wr_i, per_wr_i};
  assign b_swap = {tc_ev & cfg_cmp_swap_i, tc_ev & cfg_per_swap_i};
  assign b_data = {cmp_data_i, per_data_i};

  for (genvar gi = 0; gi < NBUF; gi++) begin : g_buf
    tpc_dbuf #(.W(CW)) u_buf (
      .clk     (clk),
      .rst_n   (rst_s_n),
      .wr_i    (b_wr[gi]),
      .data_i  (b_data[gi]),
      .direct_i(~run_q),
      .swap_i  (b_swap[gi]),
      .act_o   (b_act[gi])
    );
  end

  assign per_act = b_act[0];
  assign cmp_act = b_act[1];

  tpc_step #(.W(CW)) u_step (
    .dir_i   (dir),
    .cnt_i   (cnt_q),
    .per_i   (per_act),
    .up_i    (up_q),
    .nxt_o   (nxt),
    .nxt_up_o(nxt_up),
    .ovf_o   (st_ovf),
    .unf_o   (st_unf),
    .tc_o    (st_tc)
  );

  // next state
  always_comb begin
    tick     = cfg_ext_cnt_i ? (run_q & ev_count_i) : pre_tick;
    adv      = tick & ~ev_reload_i;
    match    = adv && (nxt == cmp_act);
    tc_ev    = adv & st_tc;
    cap_fire = cfg_cap_mode_i & ev_capture_i;

    run_d = ev_stop_i ? 1'b0 : (ev_start_i ? 1'b1 : run_q);

    if (ev_reload_i) begin
      cnt_d = (dir == DIR_DOWN) ? per_act : '0;
      up_d  = 1'b1;
    end else if (adv) begin
      cnt_d = nxt;
      up_d  = nxt_up;
    end else begin
      cnt_d = cnt_q;
      up_d  = up_q;
    end

    line_d = line_q;
    if (adv) begin
      if (dir == DIR_UPDN) begin
        if (match) line_d = ~line_q;
      end else if (match) begin
        line_d = 1'b0;
      end else if (tc_ev) begin
        line_d = 1'b1;
      end
    end

    cap_d = cap_fire ? cnt_q : cap_q;
    cc_d  = (~cfg_cap_mode_i & match) | cap_fire;
    ovf_d = adv & st_ovf;
    unf_d = adv & st_unf;
    irq_d = tc_ev | cc_d;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      up_q   <= 1'b1;
      line_q <= 1'b0;
      cap_q  <= '0;
      ovf_q  <= 1'b0;
      unf_q  <= 1'b0;
      cc_q   <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      run_q  <= run_d;
      cnt_q  <= cnt_d;
      up_q   <= up_d;
      line_q <= line_d;
      cap_q  <= cap_d;
      ovf_q  <= ovf_d;
      unf_q  <= unf_d;
      cc_q   <= cc_d;
      irq_q  <= irq_d;
    end
  end

  assign count_o   = cnt_q;
  assign capture_o = cap_q;
  assign line_o    = line_q;
  assign line_n_o  = ~line_q;
  assign ovf_o     = ovf_q;
  assign unf_o     = unf_q;
  assign cc_o      = cc_q;
  assign irq_o     = irq_q;
endmodule

// File: rtl/tpc_core_chk.sv
module tpc_core_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    cfg_dir_i,
  input logic          cfg_cap_mode_i,
  input logic          ev_stop_i,
  input logic          ev_reload_i,
  input logic          ev_capture_i,
  input logic [CW-1:0] count_o,
  input logic [CW-1:0] capture_o,
  input logic          ovf_o,
  input logic          unf_o,
  input logic          cc_o,
  input logic          irq_o
);
  // R2: an up-mode wrap shows a zero count
  a_r2_ovf_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_o && $past(cfg_dir_i) == 2'b00) |-> count_o == '0);

  // R3: one step is never both a top and a bottom turn
  a_r3_no_dual_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf_o && unf_o));

  // R6: one cycle after a stop takes effect, the count holds unless reloaded
  a_r6_stop_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ev_stop_i, 2) && !$past(ev_reload_i)) |-> $stable(count_o));

  // R10: capture takes the pre-edge count
  a_r10_capture_value: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_cap_mode_i && ev_capture_i) |=> capture_o == $past(count_o));

  // R9: without a capture in capture mode, the captured value holds
  a_r9_capture_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_cap_mode_i && ev_capture_i) |=> $stable(capture_o));

  // R13: an interrupt always comes with an event pulse
  a_r13_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (ovf_o || unf_o || cc_o));
endmodule

bind tpc_core tpc_core_chk #(.CW(CW)) u_chk (.*);

// File: tb/tpc_core_tb.sv
`timescale 1ns/100ps
module tpc_core_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  cfg_dir;
  logic [2:0]  cfg_div;
  logic        cfg_cap, cfg_ext, cfg_pswap, cfg_cswap;
  logic        per_wr, cmp_wr;
  logic [15:0] per_data, cmp_data;
  logic        ev_start, ev_stop, ev_reload, ev_count, ev_capture;
  logic [15:0] count_o, capture_o;
  logic        line_o, line_n_o, ovf_o, unf_o, cc_o, irq_o;

  always #2.5 clk = ~clk;

  tpc_core dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_dir_i(cfg_dir), .cfg_div_i(cfg_div),
    .cfg_cap_mode_i(cfg_cap), .cfg_ext_cnt_i(cfg_ext),
    .cfg_per_swap_i(cfg_pswap), .cfg_cmp_swap_i(cfg_cswap),
    .per_wr_i(per_wr), .per_data_i(per_data), .cmp_wr_i(cmp_wr),
    .cmp_data_i(cmp_data), .ev_start_i(ev_start), .ev_stop_i(ev_stop),
    .ev_reload_i(ev_reload), .ev_count_i(ev_count), .ev_capture_i(ev_capture),
    .count_o(count_o), .capture_o(capture_o), .line_o(line_o),
    .line_n_o(line_n_o), .ovf_o(ovf_o), .unf_o(unf_o), .cc_o(cc_o),
    .irq_o(irq_o)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;
  string tag = "R1";

  // behavioural reference state
  int m_cnt, m_per, m_cmp, m_pbuf, m_cbuf, m_cap, m_pre;
  bit m_run, m_up, m_line, m_ovf, m_unf, m_cc, m_irq;

  task automatic model_reset();
    m_cnt = 0; m_per = 0; m_cmp = 0; m_pbuf = 0; m_cbuf = 0; m_cap = 0;
    m_pre = 0; m_run = 0; m_up = 1; m_line = 0;
    m_ovf = 0; m_unf = 0; m_cc = 0; m_irq = 0;
  endtask

  task automatic model_step();
    int  mask = (1 << cfg_div) - 1;
    int  old_cnt = m_cnt;
    int  n;
    bit  tick, tc, match, old_run;
    old_run = m_run;
    tick  = cfg_ext ? (m_run && ev_count) : (m_run && ((m_pre & mask) == mask));
    m_pre = m_run ? (m_pre + 1) % 128 : 0;
    m_ovf = 0; m_unf = 0; m_cc = 0; tc = 0; match = 0;
    if (ev_reload) begin
      m_cnt = (cfg_dir == 2'b01) ? m_per : 0;
      m_up  = 1;
    end else if (tick) begin
      n = old_cnt;
      if (cfg_dir == 2'b01) begin
        if (n == 0) begin n = m_per; m_unf = 1; tc = 1; end
        else n = n - 1;
      end else if (cfg_dir == 2'b10) begin
        if (m_up) begin
          if (n == m_per) begin m_ovf = 1; m_up = 0; n = (m_per == 0) ? 0 : n - 1; end
          else n = (n + 1) & 16'hFFFF;
        end else begin
          if (n == 0) begin m_unf = 1; tc = 1; m_up = 1; n = (m_per == 0) ? 0 : 1; end
          else n = n - 1;
        end
      end else begin
        if (n == m_per) begin n = 0; m_ovf = 1; tc = 1; end
        else n = (n + 1) & 16'hFFFF;
      end
      match = (n == m_cmp);
      if (cfg_dir == 2'b10) begin
        if (match) m_line = !m_line;
      end else if (match) m_line = 0;
      else if (tc) m_line = 1;
      m_cnt = n;
    end
    if (cfg_cap && ev_capture) begin m_cap = old_cnt; m_cc = 1; end
    if (!cfg_cap && match) m_cc = 1;
    if (tc) begin
      if (cfg_pswap) m_per = m_pbuf;
      if (cfg_cswap) m_cmp = m_cbuf;
    end
    if (per_wr) begin m_pbuf = per_data; if (!old_run) m_per = per_data; end
    if (cmp_wr) begin m_cbuf = cmp_data; if (!old_run) m_cmp = cmp_data; end
    if (ev_stop) m_run = 0; else if (ev_start) m_run = 1;
    m_irq = tc || m_cc;
  endtask

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk(tag,   "count",   count_o,   m_cnt);
    chk("R10", "capture", capture_o, m_cap);
    chk("R11", "line",    line_o,    m_line);
    chk("R12", "line_n",  line_n_o,  !m_line);
    chk("R2",  "ovf",     ovf_o,     m_ovf);
    chk("R3",  "unf",     unf_o,     m_unf);
    chk("R9",  "cc",      cc_o,      m_cc);
    chk("R13", "irq",     irq_o,     m_irq);
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
    ev_start = 0; ev_stop = 0; ev_reload = 0; ev_count = 0; ev_capture = 0;
    per_wr = 0; cmp_wr = 0;
  endtask

  task automatic run_n(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    rst_n = 0; cfg_dir = 0; cfg_div = 0; cfg_cap = 0; cfg_ext = 0;
    cfg_pswap = 0; cfg_cswap = 0; per_wr = 0; cmp_wr = 0;
    per_data = 0; cmp_data = 0; ev_start = 0; ev_stop = 0;
    ev_reload = 0; ev_count = 0; ev_capture = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    tag = "R1";
    run_n(4);

    // R2: up mode, period 5, compare 2
    tag = "R2";
    per_wr = 1; per_data = 5; cmp_wr = 1; cmp_data = 2; cyc();
    ev_start = 1; cyc();
    run_n(20);

    // R9: capture strobes ignored in compare mode
    tag = "R9";
    ev_capture = 1; cyc(); run_n(3);
    ev_capture = 1; cyc(); run_n(2);

    // R6: stop, restart, simultaneous stop+start
    tag = "R6";
    ev_stop = 1; cyc(); run_n(6);
    ev_start = 1; cyc(); run_n(4);
    ev_stop = 1; ev_start = 1; cyc(); run_n(5);
    ev_start = 1; cyc();

    // R5: divider settings
    tag = "R5";
    cfg_div = 2; run_n(30);
    cfg_div = 7; run_n(300);
    cfg_div = 0; run_n(3);

    // R8: buffered writes while running
    tag = "R8";
    per_wr = 1; per_data = 3; cyc(); run_n(20);
    cfg_pswap = 1; run_n(20);
    cmp_wr = 1; cmp_data = 1; cyc(); run_n(6);
    cfg_cswap = 1; run_n(20);

    // R7 / R3: reload and down mode
    tag = "R7";
    ev_stop = 1; cyc(); cyc();
    cfg_dir = 2'b01; per_wr = 1; per_data = 6; cyc();
    ev_reload = 1; cyc(); run_n(3);
    tag = "R3";
    ev_start = 1; cyc(); run_n(25);
    tag = "R7";
    ev_reload = 1; cyc(); run_n(5);

    // R4: up/down mode
    tag = "R4";
    ev_stop = 1; cyc(); cyc();
    cfg_dir = 2'b10; per_wr = 1; per_data = 6; cmp_wr = 1; cmp_data = 2; cyc();
    ev_reload = 1; cyc();
    ev_start = 1; cyc(); run_n(40);

    // R10: capture mode
    tag = "R10";
    cfg_cap = 1;
    for (int k = 0; k < 5; k++) begin
      ev_capture = 1; cyc(); run_n(k + 1);
    end
    cfg_cap = 0;

    // R14: external count strobes
    tag = "R14";
    cfg_ext = 1; cfg_div = 5;
    for (int i = 0; i < 30; i++) begin
      ev_count = (i % 3 == 0); cyc();
    end
    cfg_ext = 0; cfg_div = 0;

    // R11: compare above period and compare of zero in up mode
    tag = "R11";
    ev_stop = 1; cyc(); cyc();
    cfg_dir = 2'b00; per_wr = 1; per_data = 4; cmp_wr = 1; cmp_data = 7; cyc();
    ev_reload = 1; cyc();
    ev_start = 1; cyc(); run_n(15);
    cmp_wr = 1; cmp_data = 0; cyc(); run_n(15);

    finish_run();
  end
endmodule